// File: doc/BRIEF.md
# Readback Packet Word FIFO

This block buffers readback data returned by configuration rows before a bus master collects it. Each returning packet carries 128 bits, offered on a single-cycle valid/data port, and is stored as four 32-bit words. A bus-side read strobe removes one word per access, oldest first.

Storage is accepted a packet at a time. A packet enters only when the buffer has space for all four of its words. Otherwise none of its words are stored, a one-cycle drop pulse is raised, and a sticky drop flag is set that remains set until the clear input is asserted. The read side never stalls: a read from an empty buffer returns zero and leaves the buffer unchanged. A write directed at the read port has no effect on the contents and raises a one-cycle error pulse. The default depth is 2048 words, which is 8 KiB of storage.

Top module: `rbf_readback_fifo`

## Requirements
- R1: After reset the buffer is empty, `rd_data`, `drop_err`, `wr_err` and `drop_sticky` are all 0, and a read returns 0.
- R2: A packet offered while at least four words are free is stored in full. Its words are read back in lane order 0, 1, 2, 3, where lane i is `pkt_data[32*i+31 : 32*i]`, and `drop_err` stays 0 in the following cycle.
- R3: A packet offered while fewer than four words are free stores none of its words. `drop_err` is 1 in the cycle after the offer, and the words that later reads return are unchanged.
- R4: A read while the buffer is non-empty removes the oldest word. That word appears on `rd_data` in the cycle after `rd_req`, and `rd_data` holds its value until the next read.
- R5: A read while the buffer is empty returns 0 on `rd_data` in the following cycle and removes nothing.
- R6: `wr_req` does not change the contents, and `wr_err` is 1 in the cycle after `wr_req`.
- R7: `drop_sticky` is set by every dropped packet and stays set until a cycle with `drop_clr` high and no drop. If a drop and `drop_clr` occur in the same cycle, the flag ends up set.
- R8: A packet accepted in the same cycle as a read is stored, and the read is also performed. Free space for that packet is judged from the occupancy before the read.
- R9: The capacity is exactly DEPTH words: DEPTH/4 packets are accepted into an empty buffer, and the next packet is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties the buffer |
| pkt_valid | input | 1 | A readback packet is offered this cycle |
| pkt_data | input | 128 | Packet payload; lane i is bits 32*i+31 down to 32*i |
| rd_req | input | 1 | Bus read of the word port |
| wr_req | input | 1 | Bus write to the word port (invalid access) |
| drop_clr | input | 1 | Clears the sticky drop flag |
| rd_data | output | 32 | Word returned by the most recent read, valid the cycle after `rd_req` |
| drop_err | output | 1 | One-cycle pulse after a packet was dropped |
| drop_sticky | output | 1 | Set by a drop, held until cleared |
| wr_err | output | 1 | One-cycle pulse after a write to the read port |

## Verification
The bench builds the block with DEPTH = 8, so the buffer holds two packets. This makes every occupancy from 0 to 8 reachable within a few cycles. The bench sweeps each starting fill level and each number of reads, then offers a packet, which hits both sides of the four-free-words boundary, including fill levels 5 to 7 where a partial packet would still fit. At every level it also issues a push together with a read, mixes in writes to the read port, and drains the buffer past empty.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned LANES  = 4;
    localparam int unsigned PKT_W  = WORD_W * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PKT_W-1:0]  pkt_t;
endpackage

// File: rtl/rbf_storage.sv
module rbf_storage
    import rbf_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_base,
    input  pkt_t          wr_pkt,
    input  logic [AW-1:0] rd_addr,
    output word_t         rd_word
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < int'(LANES); i++) begin
                mem[wr_base + AW'(i)] <= wr_pkt[i*WORD_W +: WORD_W];
            end
        end
    end

    assign rd_word = mem[rd_addr];

    // R2: lane 0 lands at the base address of the packet
    a_r2_lane0_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_base)] == $past(wr_pkt[WORD_W-1:0]));
endmodule

// File: rtl/rbf_ctrl.sv
module rbf_ctrl
    import rbf_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_valid,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          drop_clr,
    input  word_t         mem_word,
    output logic          push,
    output logic [AW-1:0] wr_base,
    output logic [AW-1:0] rd_addr,
    output word_t         rd_data,
    output logic          drop_err,
    output logic          drop_sticky,
    output logic          wr_err
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          sticky;
        logic          drop;
        logic          werr;
        word_t         rdata;
    } state_t;

    state_t st_q, st_d;
    logic [CW-1:0] free_words;
    logic          pop;

    always_comb begin
        free_words = CW'(DEPTH) - st_q.count;
        push       = pkt_valid && (free_words >= CW'(LANES));
        pop        = rd_req && (st_q.count != '0);

        st_d      = st_q;
        st_d.drop = pkt_valid && !push;
        st_d.werr = wr_req;

        if (push) begin
            st_d.wr_ptr = st_q.wr_ptr + AW'(LANES);
        end
        if (pop) begin
            st_d.rd_ptr = st_q.rd_ptr + AW'(1);
        end
        st_d.count = st_q.count + (push ? CW'(LANES) : CW'(0)) - (pop ? CW'(1) : CW'(0));

        if (rd_req) begin
            st_d.rdata = pop ? mem_word : '0;
        end

        if (st_d.drop) begin
            st_d.sticky = 1'b1;
        end else if (drop_clr) begin
            st_d.sticky = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_base     = st_q.wr_ptr;
    assign rd_addr     = st_q.rd_ptr;
    assign rd_data     = st_q.rdata;
    assign drop_err    = st_q.drop;
    assign drop_sticky = st_q.sticky;
    assign wr_err      = st_q.werr;

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(DEPTH));

    a_r3_drop_when_short: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && (CW'(DEPTH) - st_q.count) < CW'(LANES)) |=> drop_err);

    a_r2_accept_with_room: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && (CW'(DEPTH) - st_q.count) >= CW'(LANES)) |=> !drop_err);

    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && st_q.count == '0) |=> (rd_data == '0 && $stable(st_q.rd_ptr)));

    a_r6_write_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> wr_err);

    a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_sticky && !drop_clr) |=> drop_sticky);

    a_r8_push_and_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> st_q.count == $past(st_q.count) + CW'(LANES - 1));
endmodule

// File: rtl/rbf_readback_fifo.sv
module rbf_readback_fifo
    import rbf_pkg::*;
#(
    parameter int unsigned DEPTH = 2048
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pkt_valid,
    input  logic [127:0] pkt_data,
    input  logic         rd_req,
    input  logic         wr_req,
    input  logic         drop_clr,
    output logic [31:0]  rd_data,
    output logic         drop_err,
    output logic         drop_sticky,
    output logic         wr_err
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic          push;
    logic [AW-1:0] wr_base;
    logic [AW-1:0] rd_addr;
    word_t         mem_word;

    rbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pkt_valid   (pkt_valid),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .drop_clr    (drop_clr),
        .mem_word    (mem_word),
        .push        (push),
        .wr_base     (wr_base),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .drop_err    (drop_err),
        .drop_sticky (drop_sticky),
        .wr_err      (wr_err)
    );

    rbf_storage #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_base (wr_base),
        .wr_pkt  (pkt_data),
        .rd_addr (rd_addr),
        .rd_word (mem_word)
    );

    // R1: outputs are quiet in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data == '0 && !drop_err && !drop_sticky && !wr_err));
endmodule

// File: tb/rbf_readback_fifo_test.sv
module rbf_readback_fifo_test;
    localparam int DEPTH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pkt_valid = 1'b0;
    logic [127:0] pkt_data = '0;
    logic         rd_req = 1'b0;
    logic         wr_req = 1'b0;
    logic         drop_clr = 1'b0;
    logic [31:0]  rd_data;
    logic         drop_err;
    logic         drop_sticky;
    logic         wr_err;

    int checks = 0;
    int errors = 0;
    int pkt_id = 0;
    logic [31:0] model [$];
    logic [31:0] exp_rd = '0;
    logic        exp_sticky = 1'b0;
    string       phase = "R1";

    always #4 clk = ~clk;

    rbf_readback_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .rd_req(rd_req), .wr_req(wr_req), .drop_clr(drop_clr),
        .rd_data(rd_data), .drop_err(drop_err), .drop_sticky(drop_sticky),
        .wr_err(wr_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (phase %s): actual %0h expected %0h", req, phase, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_pkt(input int id);
        logic [127:0] p;
        for (int i = 0; i < 4; i++) p[i*32 +: 32] = 32'hA000_0000 + 32'(id * 16 + i);
        return p;
    endfunction

    // One clock: drive at negedge, check registered outputs at the next negedge
    task automatic step(input logic pv, input logic rd, input logic wr, input logic clr);
        int  cnt = model.size();
        logic acc = pv && (DEPTH - cnt) >= 4;
        logic pop = rd && cnt > 0;
        logic drop = pv && !acc;
        logic [127:0] p = mk_pkt(pkt_id);
        string rtag = (cnt > 0) ? "R4" : "R5";
        pkt_valid = pv; pkt_data = p; rd_req = rd; wr_req = wr; drop_clr = clr;
        if (rd) exp_rd = pop ? model[0] : 32'h0;
        if (pop) void'(model.pop_front());
        if (acc) for (int i = 0; i < 4; i++) model.push_back(p[i*32 +: 32]);
        exp_sticky = drop | (exp_sticky & ~clr);
        if (pv) pkt_id++;
        @(posedge clk);
        @(negedge clk);
        pkt_valid = 1'b0; rd_req = 1'b0; wr_req = 1'b0; drop_clr = 1'b0;
        check(rtag, rd_data, exp_rd);
        check(drop ? "R3" : "R2", 32'(drop_err), 32'(drop));
        check("R6", 32'(wr_err), 32'(wr));
        check("R7", 32'(drop_sticky), 32'(exp_sticky));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model.delete();
        exp_rd = '0; exp_sticky = 1'b0;
        check("R1", rd_data, 32'h0);
        check("R1", {29'h0, drop_err, drop_sticky, wr_err}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        phase = "R1";
        do_reset();
        step(0, 1, 0, 0);          // R5: empty read after reset returns 0

        // R9: fill to capacity, then one more packet is dropped
        phase = "R9";
        for (int k = 0; k < DEPTH / 4; k++) step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        while (model.size() > 0) step(0, 1, 0, 0);
        step(0, 1, 0, 0);

        // R2 R3 R4 R5 R6: sweep fill level and read count, then offer a packet
        for (int c = 0; c <= DEPTH / 4; c++) begin
            for (int p = 0; p <= c * 4; p++) begin
                phase = "R2";
                do_reset();
                for (int k = 0; k < c; k++) step(1, 0, 0, 0);
                for (int k = 0; k < p; k++) step(0, 1, (k % 3) == 1, 0);
                phase = "R3";
                step(1, 0, 0, 0);
                phase = "R8";
                step(1, 1, 0, 0);
                phase = "R6";
                step(0, 0, 1, 0);
                phase = "R4";
                while (model.size() > 0) step(0, 1, 0, 0);
                phase = "R5";
                step(0, 1, 0, 0);
            end
        end

        // R7: sticky flag clearing, and drop coinciding with clear
        phase = "R7";
        do_reset();
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);          // dropped
        step(0, 0, 0, 0);          // flag held
        step(1, 0, 0, 1);          // drop and clear together: stays set
        step(0, 0, 0, 1);          // cleared
        step(0, 0, 0, 0);
        while (model.size() > 0) step(0, 1, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule